// File: doc/BRIEF.md
# Offset Nonce Counter Bank

This block feeds the nonce field of the message word into every round of a fully unrolled, deeply pipelined hash core. The obvious approach drags each nonce down the pipeline beside its hash state in a wide delay line. This block avoids that. It holds one counter per round, and each counter is wired permanently to the point where that round reads the nonce. Every counter advances on the same enabled cycles. Each one starts from the load value minus the number of pipeline cycles between the entry and its own round. As a result, every counter always shows the nonce of the hash that is passing its round at that moment.

One more counter sits at the full pipeline depth. It names the nonce whose hash is leaving the pipeline in the current cycle. A qualifying flag goes high once the pipeline has filled after a load. The host presents a start nonce with `load_i`. It then raises `en_i` on every cycle in which the hash pipeline advances. Round lanes are packed into one flat output, with round k at bits `[k*NONCE_W +: NONCE_W]`.

Top module: `nonce_counter_bank`

## Requirements
- R1: After reset, round lane k holds (0 - offset_k) mod 2^48, the completion lane holds (0 - 96) mod 2^48, and `done_valid_o` is 0.
- R2: When `load_i` is high at a clock edge, from that edge on round lane k equals (start - offset_k) mod 2^48 and the completion lane equals (start - 96) mod 2^48. The default offsets are 0, 8, 20, 30, 38, 46, 54, 62, 70, 78, 86, 90 for rounds 0 to 11.
- R3: When `en_i` is high and `load_i` is low at an edge, every lane, including the completion lane, increases by exactly 1, wrapping from 2^48-1 to 0.
- R4: When both `load_i` and `en_i` are low at an edge, no lane changes and `done_valid_o` keeps its value.
- R5: When `load_i` and `en_i` are both high, the load is applied and the increment is not.
- R6: At any time, round lane k equals the nonce that entered round 0 exactly offset_k enabled cycles earlier. Stalled cycles do not count. Before the first entry after a load, the nonce that would have entered is start - j for j enabled cycles back.
- R7: The completion lane equals the nonce that entered round 0 exactly 96 enabled cycles earlier.
- R8: `done_valid_o` is 0 right after a load. It becomes 1 at the edge of the 96th enabled cycle after that load and then stays 1 until the next load.
- R9: Neighbouring lanes always differ by the difference of their offsets: lane k minus lane k+1 equals offset_(k+1) - offset_k, and lane 11 minus the completion lane equals 96 - offset_11, all mod 2^48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Preset all lanes from `start_nonce_i` |
| en_i | input | 1 | Pipeline advances this cycle; all lanes increment |
| start_nonce_i | input | 48 | Nonce of the first hash entering after a load |
| round_nonce_o | output | 576 | Per-round nonce lanes, round k at bits [k*48 +: 48] |
| done_nonce_o | output | 48 | Nonce of the hash leaving the pipeline |
| done_valid_o | output | 1 | Pipeline has filled since the last load |

## Verification
Every output is a register. A load or an enabled cycle therefore shows at the outputs after the single rising edge that samples it. The bench drives inputs on the falling edge and compares all lanes at the following falling edge, against a history model updated only at that edge. The valid flag follows the same rule: its expected value comes from a count of enabled edges since the last load, so its rise is checked at the exact edge of the 96th enabled cycle.

// File: rtl/nonce_bank_pkg.sv
package nonce_bank_pkg;

    typedef enum logic [1:0] {
        LANE_HOLD = 2'd0,
        LANE_STEP = 2'd1,
        LANE_LOAD = 2'd2
    } lane_cmd_e;

    localparam int unsigned DEF_ROUNDS = 12;
    localparam int unsigned DEF_FILL   = 96;

    // cycle distance from pipeline entry to each round's nonce tap
    localparam int unsigned DEF_OFFSETS [DEF_ROUNDS] =
        '{0, 8, 20, 30, 38, 46, 54, 62, 70, 78, 86, 90};

    function automatic lane_cmd_e decode_cmd(input logic load, input logic en);
        if (load)    return LANE_LOAD;
        else if (en) return LANE_STEP;
        else         return LANE_HOLD;
    endfunction

endpackage

// File: rtl/nonce_lane.sv
module nonce_lane
    import nonce_bank_pkg::*;
#(
    parameter int unsigned NONCE_W = 48,
    parameter int unsigned OFFSET  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lane_cmd_e          cmd_i,
    input  logic [NONCE_W-1:0] start_i,
    output logic [NONCE_W-1:0] value_o
);
    localparam logic [NONCE_W-1:0] OFF_V   = NONCE_W'(OFFSET);
    localparam logic [NONCE_W-1:0] RESET_V = '0 - OFF_V;

    typedef struct packed {
        logic [NONCE_W-1:0] val;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd_i)
            LANE_LOAD: st_d.val = start_i - OFF_V;
            LANE_STEP: st_d.val = st_q.val + 1'b1;
            default:   st_d.val = st_q.val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{val: RESET_V};
        else        st_q <= st_d;
    end

    assign value_o = st_q.val;
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker
    import nonce_bank_pkg::*;
#(
    parameter int unsigned FILL = 96
) (
    input  logic      clk,
    input  logic      rst_n,
    input  lane_cmd_e cmd_i,
    output logic      full_o
);
    localparam int unsigned   CW     = $clog2(FILL + 1);
    localparam logic [CW-1:0] FILL_V = CW'(FILL);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          full;
    } fill_state_t;

    fill_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd_i)
            LANE_LOAD: st_d.cnt = '0;
            LANE_STEP: if (st_q.cnt != FILL_V) st_d.cnt = st_q.cnt + 1'b1;
            default:   st_d.cnt = st_q.cnt;
        endcase
        st_d.full = (st_d.cnt == FILL_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o = st_q.full;
endmodule

// File: rtl/nonce_counter_bank.sv
module nonce_counter_bank
    import nonce_bank_pkg::*;
#(
    parameter int unsigned NONCE_W    = 48,
    parameter int unsigned NUM_ROUNDS = DEF_ROUNDS,
    parameter int unsigned FILL       = DEF_FILL,
    parameter int unsigned RND_OFFSET [NUM_ROUNDS] = DEF_OFFSETS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic                          en_i,
    input  logic [NONCE_W-1:0]            start_nonce_i,
    output logic [NUM_ROUNDS*NONCE_W-1:0] round_nonce_o,
    output logic [NONCE_W-1:0]            done_nonce_o,
    output logic                          done_valid_o
);
    lane_cmd_e cmd;

    always_comb cmd = decode_cmd(load_i, en_i);

    for (genvar k = 0; k < NUM_ROUNDS; k++) begin : g_round
        nonce_lane #(
            .NONCE_W (NONCE_W),
            .OFFSET  (RND_OFFSET[k])
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_i   (cmd),
            .start_i (start_nonce_i),
            .value_o (round_nonce_o[k*NONCE_W +: NONCE_W])
        );
    end

    nonce_lane #(
        .NONCE_W (NONCE_W),
        .OFFSET  (FILL)
    ) u_done_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd),
        .start_i (start_nonce_i),
        .value_o (done_nonce_o)
    );

    fill_tracker #(
        .FILL (FILL)
    ) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd),
        .full_o (done_valid_o)
    );
endmodule

// File: rtl/nonce_bank_checker.sv
module nonce_bank_checker #(
    parameter int unsigned NONCE_W    = 48,
    parameter int unsigned NUM_ROUNDS = 12,
    parameter int unsigned FILL       = 96,
    parameter int unsigned RND_OFFSET [NUM_ROUNDS] = nonce_bank_pkg::DEF_OFFSETS
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          load_i,
    input logic                          en_i,
    input logic [NONCE_W-1:0]            start_nonce_i,
    input logic [NUM_ROUNDS*NONCE_W-1:0] round_nonce_o,
    input logic [NONCE_W-1:0]            done_nonce_o,
    input logic                          done_valid_o
);
    logic [NONCE_W-1:0] lane0;
    assign lane0 = round_nonce_o[NONCE_W-1:0];

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (lane0 == $past(start_nonce_i)));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i) |=> (done_nonce_o == $past(done_nonce_o) + 1'b1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> ($stable(round_nonce_o) && $stable(done_nonce_o)
                                && $stable(done_valid_o)));

    assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && en_i) |=> (done_nonce_o == $past(start_nonce_i) - NONCE_W'(FILL)));

    assert_valid_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !done_valid_o);

    for (genvar k = 0; k + 1 < NUM_ROUNDS; k++) begin : g_gap
        assert_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (round_nonce_o[k*NONCE_W +: NONCE_W] - round_nonce_o[(k+1)*NONCE_W +: NONCE_W])
                == NONCE_W'(RND_OFFSET[k+1] - RND_OFFSET[k]));
    end

    assert_tail_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (round_nonce_o[(NUM_ROUNDS-1)*NONCE_W +: NONCE_W] - done_nonce_o)
            == NONCE_W'(FILL - RND_OFFSET[NUM_ROUNDS-1]));
endmodule

bind nonce_counter_bank nonce_bank_checker #(
    .NONCE_W    (NONCE_W),
    .NUM_ROUNDS (NUM_ROUNDS),
    .FILL       (FILL),
    .RND_OFFSET (RND_OFFSET)
) u_chk (.*);

// File: tb/nonce_counter_bank_test.sv
module nonce_counter_bank_test;
    localparam int W  = 48;
    localparam int NR = 12;
    localparam int FL = 96;
    localparam int unsigned OFFS [NR] = '{0, 8, 20, 30, 38, 46, 54, 62, 70, 78, 86, 90};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic              en_i = 1'b0;
    logic [W-1:0]      start_nonce_i = '0;
    logic [NR*W-1:0]   round_nonce_o;
    logic [W-1:0]      done_nonce_o;
    logic              done_valid_o;

    int tests = 0;
    int fails = 0;
    string tag = "R1";

    // reference delay line: hist[j] = nonce that entered j enabled cycles ago
    logic [W-1:0] hist [0:FL];
    int           fill_cnt;

    always #10 clk = ~clk;

    nonce_counter_bank uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load_i),
        .en_i          (en_i),
        .start_nonce_i (start_nonce_i),
        .round_nonce_o (round_nonce_o),
        .done_nonce_o  (done_nonce_o),
        .done_valid_o  (done_valid_o)
    );

    function automatic logic [W-1:0] exp_lane(input int k);
        return hist[OFFS[k]];
    endfunction

    task automatic model_preset(input logic [W-1:0] s);
        for (int j = 0; j <= FL; j++) hist[j] = s - W'(j);
        fill_cnt = 0;
    endtask

    task automatic model_edge(input logic ld, input logic en, input logic [W-1:0] s);
        if (ld) model_preset(s);
        else if (en) begin
            for (int j = FL; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = hist[0] + 1'b1;
            if (fill_cnt < FL) fill_cnt++;
        end
    endtask

    task automatic check(input string t, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    task automatic check_all(input string t);
        for (int k = 0; k < NR; k++)
            check(t == "" ? "R6" : t, $sformatf("round %0d", k),
                  round_nonce_o[k*W +: W], exp_lane(k));
        check(t == "" ? "R7" : t, "done nonce", done_nonce_o, hist[FL]);
        check("R8", "done valid", W'(done_valid_o), W'(fill_cnt == FL));
    endtask

    // drive at falling edge, rising edge samples, compare at next falling edge
    task automatic cycle(input logic ld, input logic en, input logic [W-1:0] s);
        load_i = ld; en_i = en; start_nonce_i = s;
        @(posedge clk);
        model_edge(ld, en, s);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h00C0FFEE);
        model_preset('0);
        repeat (3) @(negedge clk);
        // R1: reset values
        tag = "R1";
        check_all(tag);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(tag);

        // R2: load
        tag = "R2";
        cycle(1'b1, 1'b0, 48'h0000_1234_5678);

        // R4: hold
        tag = "R4";
        repeat (4) cycle(1'b0, 1'b0, 48'hFFFF_FFFF_FFFF);

        // R3: wrap across 2^48
        tag = "R2";
        cycle(1'b1, 1'b0, 48'hFFFF_FFFF_FFFD);
        tag = "R3";
        repeat (6) cycle(1'b0, 1'b1, '0);

        // R5: load and enable together
        tag = "R5";
        cycle(1'b1, 1'b1, 48'h0000_0000_0005);

        // R8: fill exactly, with stalls in between
        tag = "";
        for (int i = 0; i < FL - 1; i++) begin
            cycle(1'b0, 1'b1, '0);
            if (i % 17 == 3) cycle(1'b0, 1'b0, '0);
        end
        check("R8", "valid before last fill step", W'(done_valid_o), W'(0));
        cycle(1'b0, 1'b1, '0);
        check("R8", "valid at fill", W'(done_valid_o), W'(1));
        cycle(1'b1, 1'b0, 48'h0000_ABCD_0000);
        check("R8", "valid after reload", W'(done_valid_o), W'(0));

        // R6 / R7: random load, enable and stall mix
        tag = "";
        for (int i = 0; i < 3000; i++) begin
            logic ld, en;
            logic [W-1:0] s;
            ld = ($urandom % 200) == 0;
            en = ($urandom % 4) != 0;
            s  = {$urandom, $urandom} & {W{1'b1}};
            cycle(ld, en, s);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule